// File: doc/BRIEF.md
# Serial Control Word Loader

This block receives configuration words over a three-pin serial link (shift clock, data, load strobe) and places each one in one of four holding registers. Each word is 24 bits long and is sent most significant bit first. Bits are taken on each rising edge of the shift clock. The two bits sent last form a destination code. A rising edge on the load strobe copies the upper 22 bits of the shift register into the register that this code selects. The three pins are sampled by a faster system clock. They pass through a synchronizer before any edge is detected, so the serial side needs no clock relationship to the system side.

The four registers are the reference-divider word, the feedback-divider word, the function word and the initialization word. Each has a strobe that is high for one system clock cycle when its register is written. A write to the initialization register also loads the function register and pulses a counter-clear strobe. Only the load edge decides when a transfer happens. The number of shift clocks does not, so the most recent 24 bits in the shift register are always the ones used.

Top module: `ser_ctrl_loader`

## Requirements
- R1: While reset is high, and in the cycle after it, all four register outputs read zero and every strobe output is low.
- R2: Bits are taken MSB first on shift-clock rising edges. Transmitted word bits 23..2 appear on the selected register output as bits 21..0, so output bit k equals word bit k+2.
- R3: Word bits 1:0 select the destination: 00 selects the reference word, 01 the feedback word, 10 the function word and 11 the initialization word.
- R4: A register that a transfer does not select keeps its value.
- R5: Each transfer raises the strobe of the written register for exactly one system clock cycle. No other register strobe rises, apart from the case in R6.
- R6: A transfer with code 11 also loads the function register with the same payload, pulses the function strobe, and pulses the counter-clear strobe for one cycle.
- R7: Shift-clock activity without a load-strobe rising edge changes no output.
- R8: When more or fewer than 24 bits arrive between transfers, the transfer uses the last 24 bits shifted in. These include bits left over from earlier words.
- R9: Say a rising load edge is applied to the pin just after system clock edge 0. Registers and strobes then change on system clock edge 3, and are unchanged after edge 2.
- R10: Holding the load strobe high for many cycles causes exactly one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial shift clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| load_i | input | 1 | Load strobe, asynchronous, rising edge transfers |
| ref_word_o | output | 22 | Reference-divider register |
| ref_upd_o | output | 1 | Reference register written |
| fb_word_o | output | 22 | Feedback-divider register |
| fb_upd_o | output | 1 | Feedback register written |
| func_word_o | output | 22 | Function register |
| func_upd_o | output | 1 | Function register written |
| init_word_o | output | 22 | Initialization register |
| init_upd_o | output | 1 | Initialization register written |
| cnt_clr_o | output | 1 | Counter-clear pulse on initialization write |

## Verification
Every result is due on the third system clock rising edge after its pin changes. That is two synchronizer stages plus the register stage. The bench drives pins on falling edges. It holds each shift-clock level for several cycles, so each sampled bit is stable when its edge is detected. Register outputs are compared a few cycles after each load pulse. One test samples exactly two and three edges after the load rise to pin the latency. Strobe pulses are counted on falling edges and compared with the number of transfers expected for each destination.

// File: rtl/ser_ldr_pkg.sv
package ser_ldr_pkg;

    localparam int WORD_W  = 24;
    localparam int CTRL_W  = 2;
    localparam int PAY_W   = WORD_W - CTRL_W;
    localparam int N_DEST  = 1 << CTRL_W;

    typedef enum logic [CTRL_W-1:0] {
        DST_REF  = 2'd0,
        DST_FB   = 2'd1,
        DST_FUNC = 2'd2,
        DST_INIT = 2'd3
    } dest_e;

    // Control code sits in the last bits shifted, i.e. the LSBs
    typedef struct packed {
        logic [PAY_W-1:0] payload;
        dest_e            dest;
    } word_t;

    typedef struct packed {
        logic sclk;
        logic sdata;
        logic load;
    } pins_t;

    localparam int PIN_W = $bits(pins_t);

    // Which holding registers a given code writes
    function automatic logic [N_DEST-1:0] dest_mask(input dest_e d);
        logic [N_DEST-1:0] m;
        m = '0;
        m[d] = 1'b1;
        if (d == DST_INIT) begin
            m[DST_FUNC] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/ser_ldr_sync.sv
module ser_ldr_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ser_ldr_shift.sv
module ser_ldr_shift
    import ser_ldr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t pins_i,
    output word_t word_o,
    output logic  load_o
);
    logic [WORD_W-1:0] sreg_q;
    logic              sclk_prev_q;
    logic              load_prev_q;
    logic              shift_en;

    assign shift_en = pins_i.sclk & ~sclk_prev_q;
    assign load_o   = pins_i.load & ~load_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q      <= '0;
            sclk_prev_q <= 1'b0;
            load_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= pins_i.sclk;
            load_prev_q <= pins_i.load;
            if (shift_en) begin
                sreg_q <= {sreg_q[WORD_W-2:0], pins_i.sdata};
            end
        end
    end

    assign word_o = word_t'(sreg_q);
endmodule

// File: rtl/ser_ldr_bank.sv
module ser_ldr_bank
    import ser_ldr_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  word_t                         word_i,
    input  logic                          load_i,
    output logic [N_DEST-1:0][PAY_W-1:0]  regs_o,
    output logic [N_DEST-1:0]             upd_o,
    output logic                          clr_o
);
    logic [N_DEST-1:0] wr_en;

    assign wr_en = load_i ? dest_mask(word_i.dest) : '0;

    for (genvar g = 0; g < N_DEST; g++) begin : g_reg
        logic [PAY_W-1:0] val_q;
        logic             upd_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '0;
                upd_q <= 1'b0;
            end else begin
                upd_q <= wr_en[g];
                if (wr_en[g]) begin
                    val_q <= word_i.payload;
                end
            end
        end
        assign regs_o[g] = val_q;
        assign upd_o[g]  = upd_q;
    end

    logic clr_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            clr_q <= 1'b0;
        end else begin
            clr_q <= load_i && (word_i.dest == DST_INIT);
        end
    end
    assign clr_o = clr_q;
endmodule

// File: rtl/ser_ctrl_loader.sv
module ser_ctrl_loader
    import ser_ldr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_i,
    input  logic             sdata_i,
    input  logic             load_i,
    output logic [PAY_W-1:0] ref_word_o,
    output logic             ref_upd_o,
    output logic [PAY_W-1:0] fb_word_o,
    output logic             fb_upd_o,
    output logic [PAY_W-1:0] func_word_o,
    output logic             func_upd_o,
    output logic [PAY_W-1:0] init_word_o,
    output logic             init_upd_o,
    output logic             cnt_clr_o
);
    pins_t                        raw_pins;
    logic [PIN_W-1:0]             sync_bits;
    word_t                        cur_word;
    logic                         load_p;
    logic [N_DEST-1:0][PAY_W-1:0] regs;
    logic [N_DEST-1:0]            upd;

    assign raw_pins = '{sclk: sclk_i, sdata: sdata_i, load: load_i};

    ser_ldr_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_pins),
        .q_o (sync_bits)
    );

    ser_ldr_shift u_shift (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins_t'(sync_bits)),
        .word_o (cur_word),
        .load_o (load_p)
    );

    ser_ldr_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .word_i (cur_word),
        .load_i (load_p),
        .regs_o (regs),
        .upd_o  (upd),
        .clr_o  (cnt_clr_o)
    );

    assign ref_word_o  = regs[DST_REF];
    assign fb_word_o   = regs[DST_FB];
    assign func_word_o = regs[DST_FUNC];
    assign init_word_o = regs[DST_INIT];
    assign ref_upd_o   = upd[DST_REF];
    assign fb_upd_o    = upd[DST_FB];
    assign func_upd_o  = upd[DST_FUNC];
    assign init_upd_o  = upd[DST_INIT];
endmodule

// File: rtl/ser_ldr_chk.sv
module ser_ldr_chk
    import ser_ldr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [PAY_W-1:0] ref_word_o,
    input logic             ref_upd_o,
    input logic [PAY_W-1:0] fb_word_o,
    input logic             fb_upd_o,
    input logic [PAY_W-1:0] func_word_o,
    input logic             func_upd_o,
    input logic [PAY_W-1:0] init_word_o,
    input logic             init_upd_o,
    input logic             cnt_clr_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ref_word_o == '0 && fb_word_o == '0 && func_word_o == '0 &&
                 init_word_o == '0 && !ref_upd_o && !fb_upd_o && !func_upd_o &&
                 !init_upd_o && !cnt_clr_o));

    // R4
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ref_word_o) |-> ref_upd_o);
    // R4
    fb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(fb_word_o) |-> fb_upd_o);
    // R4
    func_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(func_word_o) |-> func_upd_o);
    // R4
    init_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(init_word_o) |-> init_upd_o);

    // R5
    single_dest_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ref_upd_o, fb_upd_o, func_upd_o & ~init_upd_o, init_upd_o}));

    // R5
    ref_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ref_upd_o |=> !ref_upd_o);
    // R5
    init_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        init_upd_o |=> !init_upd_o);

    // R6
    init_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        init_upd_o |-> (func_upd_o && cnt_clr_o && func_word_o == init_word_o));

    // R6
    clr_only_init_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_clr_o |-> init_upd_o);
endmodule

bind ser_ctrl_loader ser_ldr_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_word_o  (ref_word_o),
    .ref_upd_o   (ref_upd_o),
    .fb_word_o   (fb_word_o),
    .fb_upd_o    (fb_upd_o),
    .func_word_o (func_word_o),
    .func_upd_o  (func_upd_o),
    .init_word_o (init_word_o),
    .init_upd_o  (init_upd_o),
    .cnt_clr_o   (cnt_clr_o)
);

// File: tb/tb_ser_ctrl_loader.sv
module tb_ser_ctrl_loader;
    localparam int PW = 22;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk_i = 1'b0;
    logic sdata_i = 1'b0;
    logic load_i = 1'b0;
    logic [PW-1:0] ref_word_o, fb_word_o, func_word_o, init_word_o;
    logic ref_upd_o, fb_upd_o, func_upd_o, init_upd_o, cnt_clr_o;

    int checks = 0;
    int errors = 0;

    logic [23:0]   model_sr = '0;
    logic [PW-1:0] exp_reg [4];
    int            seen_cnt [5];
    int            exp_cnt  [5];

    always #4 clk = ~clk;

    ser_ctrl_loader dut (
        .clk(clk), .rst(rst), .sclk_i(sclk_i), .sdata_i(sdata_i), .load_i(load_i),
        .ref_word_o(ref_word_o), .ref_upd_o(ref_upd_o),
        .fb_word_o(fb_word_o), .fb_upd_o(fb_upd_o),
        .func_word_o(func_word_o), .func_upd_o(func_upd_o),
        .init_word_o(init_word_o), .init_upd_o(init_upd_o),
        .cnt_clr_o(cnt_clr_o)
    );

    // Strobe pulse counters, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            seen_cnt[0] += int'(ref_upd_o);
            seen_cnt[1] += int'(fb_upd_o);
            seen_cnt[2] += int'(func_upd_o);
            seen_cnt[3] += int'(init_upd_o);
            seen_cnt[4] += int'(cnt_clr_o);
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdata_i = b;
        tick(2);
        sclk_i = 1'b1;
        model_sr = {model_sr[22:0], b};
        tick(3);
        sclk_i = 1'b0;
        tick(2);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic apply_model();
        logic [1:0] code;
        code = model_sr[1:0];
        exp_reg[code] = model_sr[23:2];
        exp_cnt[code]++;
        if (code == 2'd3) begin
            exp_reg[2] = model_sr[23:2];
            exp_cnt[2]++;
            exp_cnt[4]++;
        end
    endtask

    task automatic pulse_load();
        load_i = 1'b1;
        apply_model();
        tick(4);
        load_i = 1'b0;
        tick(4);
    endtask

    task automatic check_all(input string req);
        chk(req, "ref word",  ref_word_o,  exp_reg[0]);
        chk(req, "fb word",   fb_word_o,   exp_reg[1]);
        chk(req, "func word", func_word_o, exp_reg[2]);
        chk(req, "init word", init_word_o, exp_reg[3]);
        for (int i = 0; i < 5; i++) chk(req, "strobe count", seen_cnt[i], exp_cnt[i]);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) exp_reg[i] = '0;
        for (int i = 0; i < 5; i++) begin
            seen_cnt[i] = 0;
            exp_cnt[i] = 0;
        end
        tick(4);
        // R1 reset state
        chk("R1", "ref",  ref_word_o,  '0);
        chk("R1", "fb",   fb_word_o,   '0);
        chk("R1", "func", func_word_o, '0);
        chk("R1", "init", init_word_o, '0);
        chk("R1", "strobes", {ref_upd_o, fb_upd_o, func_upd_o, init_upd_o, cnt_clr_o}, '0);
        rst = 1'b0;
        tick(2);
        chk("R1", "after release", {ref_word_o, fb_word_o}, '0);

        // R2 R3 R4 R5 R6: every code with several payload patterns
        for (int p = 0; p < 6; p++) begin
            for (int c = 0; c < 4; c++) begin
                logic [PW-1:0] pay;
                pay = PW'((p + 1) * 32'h0013_57AB + c * 32'h0002_4681);
                if (p == 0) pay = '1;
                if (p == 1) pay = 22'h20_0001;
                send_bits({8'h0, pay, c[1:0]}, 24);
                pulse_load();
                check_all("R3");
                chk("R2", "msb position", {10'h0, pay}, c == 0 ? ref_word_o : c == 1 ? fb_word_o :
                                                       c == 2 ? func_word_o : init_word_o);
            end
        end

        // R7: shifting without a load edge changes nothing
        send_bits(32'h00AB_CDE2, 24);
        tick(6);
        check_all("R7");

        // R8: overlong word, last 24 bits used
        send_bits(32'h5F12_3451, 32);
        pulse_load();
        check_all("R8");
        chk("R8", "overlong payload", fb_word_o, 22'h04_8D14);

        // R8: short word, older bits fill upper part
        send_bits(32'h0012_3454, 24);
        send_bits(32'h0000_0015, 10);
        pulse_load();
        check_all("R8");

        // R9: latency from load pin rise
        send_bits(32'h0033_3330, 24);
        load_i = 1'b1;
        tick(2);
        chk("R9", "unchanged after 2 edges", ref_word_o, exp_reg[0]);
        chk("R9", "no strobe after 2 edges", ref_upd_o, 1'b0);
        apply_model();
        tick(1);
        chk("R9", "written after 3 edges", ref_word_o, exp_reg[0]);
        chk("R9", "strobe after 3 edges", ref_upd_o, 1'b1);
        tick(1);
        chk("R5", "strobe one cycle", ref_upd_o, 1'b0);
        load_i = 1'b0;
        tick(4);
        check_all("R9");

        // R10: load held high for a long time
        send_bits(32'h0012_3457, 24);
        load_i = 1'b1;
        apply_model();
        tick(40);
        send_bits(32'h0000_0FFF, 12);
        tick(10);
        check_all("R10");
        load_i = 1'b0;
        tick(6);
        check_all("R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule